// File: doc/BRIEF.md
# SEC-DED Word Codec for Memory

This block protects 16-bit memory words with a six-bit single-error-correcting, double-error-detecting code. On the write side it turns a data word into the check bits that are stored next to it. On the read side it takes the stored word and its stored check bits, forms a syndrome and an overall parity result, and repairs any single flipped bit before the word is returned. A two-bit error is reported as uncorrectable, and the stored word is passed through unchanged.

Reads with no error indication come out after one cycle. Any read that shows an error indication takes one extra cycle, which models the slower response of a corrected access. Reads always leave in the order they arrived, one per cycle at most. A read that arrives while a slower read is still in the pipeline therefore also takes two cycles.

For diagnostics, the host can turn correction off so that reads return raw data with both error flags low. It can replace the generated check bits on a write with a value of its own, and it gets the raw stored check bits back with every read.

Top module: `ecc_word_codec`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, wr_valid_o, rd_valid_o, single_err_corrected_o and double_err_detected_o are all 0.
- R2: A write presented with wr_valid_i appears one cycle later on wr_valid_o, with wr_data_o equal to the data written. The data bits take codeword positions 3, 5, 6, 7, 9 to 15 and 17 to 21 in ascending order. Check bit k of wr_cb_o (k = 0..4) is the XOR of the data bits whose position has bit k set, so wr_cb_o bits 0..4 are the parities for weights 1, 2, 4, 8 and 16. Bit 5 makes the XOR of all 16 data bits and all 6 check bits equal to 0.
- R3: When wr_cb_force_i is 1 on a write, wr_cb_o one cycle later equals wr_cb_i rather than the generated value.
- R4: A read whose stored word and check bits are consistent is returned one cycle after rd_valid_i, with the data unchanged and both flags 0.
- R5: A read with exactly one flipped data bit is returned two cycles after rd_valid_i, with the original data and single_err_corrected_o set.
- R6: A read with exactly one flipped check bit, including bit 5, is returned two cycles after rd_valid_i, with the data unchanged and single_err_corrected_o set.
- R7: A nonzero syndrome together with correct overall parity, or a syndrome above 21 together with wrong overall parity, sets double_err_detected_o. The stored data is then returned uncorrected, two cycles after rd_valid_i.
- R8: While ecc_off_i is 1 at the time of a read, the raw stored data is returned one cycle later and both flags are 0.
- R9: rd_cb_raw_o, sampled with rd_valid_o, equals the check bits that were supplied with that read.
- R10: Reads leave in arrival order. A clean read that arrives in the cycle after a read with an error indication comes out one cycle after that read.
- R11: The two flags are never 1 together. Each flag is 1 only in a cycle where rd_valid_o is 1, and it stays 1 for a single cycle per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ecc_off_i | input | 1 | Diagnostic: disable correction and flags for reads |
| wr_valid_i | input | 1 | Write word present |
| wr_data_i | input | DATA_W | Write data |
| wr_cb_force_i | input | 1 | Diagnostic: use wr_cb_i as the check bits |
| wr_cb_i | input | CB_W | Explicit check bits for a forced write |
| wr_valid_o | output | 1 | Encoded write word valid |
| wr_data_o | output | DATA_W | Data to store |
| wr_cb_o | output | CB_W | Check bits to store |
| rd_valid_i | input | 1 | Stored word present for decoding |
| rd_data_i | input | DATA_W | Stored data |
| rd_cb_i | input | CB_W | Stored check bits |
| rd_valid_o | output | 1 | Decoded read word valid |
| rd_data_o | output | DATA_W | Corrected (or raw) read data |
| rd_cb_raw_o | output | CB_W | Raw stored check bits of the returned read |
| single_err_corrected_o | output | 1 | Single error corrected, pulse with rd_valid_o |
| double_err_detected_o | output | 1 | Uncorrectable error, pulse with rd_valid_o |

## Verification
The bench builds the codec with its default width of 16 data bits, which gives 6 check bits and a 21-position codeword. At this size a bench can afford to inject an error at every single position. It flips each of the 16 data bits and each of the 6 check bits one at a time, so the whole syndrome map is covered, including the case where only the overall parity bit differs. It also makes a three-bit flip whose syndrome points past position 21, and it sends a slow read and a clean read back to back to show that order is kept across the variable latency.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_DOUBLE = 2'd2
  } err_kind_e;

  // positional check bits needed for dw data bits
  function automatic int chk_count(int dw);
    int res = 0;
    for (int p = 1; p < 16; p++) begin
      if (res == 0 && ((1 << p) - p - 1) >= dw) res = p;
    end
    return res;
  endfunction

  // codeword position of data bit idx (non-power-of-two slots from 3 up)
  function automatic int data_pos(int idx);
    int cnt = 0;
    int res = 0;
    for (int q = 3; q < 512; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == idx) res = q;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned P      = 5
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [P:0]        cb_o
);
  import ecc_codec_pkg::*;

  function automatic logic [DATA_W-1:0] cover_mask(int k);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < int'(DATA_W); i++) m[i] = ((data_pos(i) >> k) & 1) != 0;
    return m;
  endfunction

  logic [P-1:0] pos_par;

  for (genvar k = 0; k < int'(P); k++) begin : g_par
    localparam logic [DATA_W-1:0] MASK = cover_mask(k);
    assign pos_par[k] = ^(data_i & MASK);
  end

  assign cb_o = {(^data_i) ^ (^pos_par), pos_par};

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned P      = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [P:0]        cb_i,
  output logic [P-1:0]      syn_o,
  output logic              par_err_o
);
  logic [P:0] regen;

  ecc_encoder #(.DATA_W(DATA_W), .P(P)) u_regen (
    .data_i (data_i),
    .cb_o   (regen)
  );

  assign syn_o     = regen[P-1:0] ^ cb_i[P-1:0];
  // overall parity of stored word: regen top bit folds data and regenerated checks
  assign par_err_o = regen[P] ^ cb_i[P] ^ (^syn_o);

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned P      = 5
) (
  input  logic [DATA_W-1:0]           data_i,
  input  logic [P-1:0]                syn_i,
  input  logic                        par_err_i,
  input  logic                        ecc_off_i,
  output logic [DATA_W-1:0]           data_o,
  output ecc_codec_pkg::err_kind_e    kind_o,
  output logic                        slow_o
);
  import ecc_codec_pkg::*;

  localparam int unsigned N_POS = DATA_W + P;

  logic              syn_nz;
  logic              syn_oor;
  logic [DATA_W-1:0] flip;

  assign syn_nz  = |syn_i;
  assign syn_oor = 32'(syn_i) > N_POS;

  always_comb begin
    kind_o = ERR_NONE;
    if (!ecc_off_i) begin
      if (!par_err_i) kind_o = syn_nz ? ERR_DOUBLE : ERR_NONE;
      else            kind_o = syn_oor ? ERR_DOUBLE : ERR_SINGLE;
    end
  end

  // syndrome at a check position matches no data bit: data untouched
  for (genvar i = 0; i < int'(DATA_W); i++) begin : g_flip
    localparam logic [P-1:0] POS = P'(data_pos(i));
    assign flip[i] = (kind_o == ERR_SINGLE) && (syn_i == POS);
  end

  assign data_o = data_i ^ flip;
  assign slow_o = !ecc_off_i && (syn_nz || par_err_i);

endmodule

// File: rtl/ecc_word_codec.sv
module ecc_word_codec #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned P     = ecc_codec_pkg::chk_count(DATA_W),
  localparam int unsigned CB_W  = P + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecc_off_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_cb_force_i,
  input  logic [CB_W-1:0]   wr_cb_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CB_W-1:0]   wr_cb_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [CB_W-1:0]   rd_cb_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CB_W-1:0]   rd_cb_raw_o,
  output logic              single_err_corrected_o,
  output logic              double_err_detected_o
);
  import ecc_codec_pkg::*;

  // ---------------- write path ----------------
  logic [CB_W-1:0] gen_cb;

  ecc_encoder #(.DATA_W(DATA_W), .P(P)) u_enc (
    .data_i (wr_data_i),
    .cb_o   (gen_cb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      wr_cb_o    <= '0;
    end else begin
      wr_valid_o <= wr_valid_i;
      if (wr_valid_i) begin
        wr_data_o <= wr_data_i;
        wr_cb_o   <= wr_cb_force_i ? wr_cb_i : gen_cb;
      end
    end
  end

  // ---------------- read path, stage 1 ----------------
  logic              s1_valid;
  logic [DATA_W-1:0] s1_data;
  logic [CB_W-1:0]   s1_cb;
  logic              s1_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_cb    <= '0;
      s1_off   <= 1'b0;
    end else begin
      s1_valid <= rd_valid_i;
      if (rd_valid_i) begin
        s1_data <= rd_data_i;
        s1_cb   <= rd_cb_i;
        s1_off  <= ecc_off_i;
      end
    end
  end

  logic [P-1:0]      s1_syn;
  logic              s1_par_err;
  logic [DATA_W-1:0] s1_fix_data;
  err_kind_e         s1_kind;
  logic              s1_slow;

  ecc_syndrome #(.DATA_W(DATA_W), .P(P)) u_syn (
    .data_i    (s1_data),
    .cb_i      (s1_cb),
    .syn_o     (s1_syn),
    .par_err_o (s1_par_err)
  );

  ecc_corrector #(.DATA_W(DATA_W), .P(P)) u_fix (
    .data_i    (s1_data),
    .syn_i     (s1_syn),
    .par_err_i (s1_par_err),
    .ecc_off_i (s1_off),
    .data_o    (s1_fix_data),
    .kind_o    (s1_kind),
    .slow_o    (s1_slow)
  );

  // ---------------- read path, stage 2 (correction / ordering) ----------------
  logic              s2_valid;
  logic [DATA_W-1:0] s2_data;
  logic [CB_W-1:0]   s2_cb;
  err_kind_e         s2_kind;
  logic              s1_move;

  // slow words always take stage 2; a fast word behind one follows it
  assign s1_move = s1_valid && (s1_slow || s2_valid);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_data  <= '0;
      s2_cb    <= '0;
      s2_kind  <= ERR_NONE;
    end else begin
      s2_valid <= s1_move;
      if (s1_move) begin
        s2_data <= s1_fix_data;
        s2_cb   <= s1_cb;
        s2_kind <= s1_kind;
      end
    end
  end

  err_kind_e out_kind;

  assign rd_valid_o  = s2_valid || (s1_valid && !s1_slow);
  assign rd_data_o   = s2_valid ? s2_data : s1_fix_data;
  assign rd_cb_raw_o = s2_valid ? s2_cb   : s1_cb;
  assign out_kind    = s2_valid ? s2_kind : s1_kind;

  assign single_err_corrected_o = rd_valid_o && (out_kind == ERR_SINGLE);
  assign double_err_detected_o  = rd_valid_o && (out_kind == ERR_DOUBLE);

endmodule

// File: rtl/ecc_word_codec_chk.sv
module ecc_word_codec_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CB_W   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wr_cb_force_i,
  input logic [CB_W-1:0]   wr_cb_i,
  input logic              wr_valid_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [CB_W-1:0]   wr_cb_o,
  input logic              rd_valid_o,
  input logic              single_err_corrected_o,
  input logic              double_err_detected_o
);

  p_flag_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single_err_corrected_o && double_err_detected_o));

  p_flag_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_err_corrected_o || double_err_detected_o) |-> rd_valid_o);

  p_wr_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> wr_valid_o);

  p_wr_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (wr_data_o == $past(wr_data_i)));

  p_force_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_cb_force_i) |=> (wr_cb_o == $past(wr_cb_i)));

  p_idle_wr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !wr_valid_o);

endmodule

bind ecc_word_codec ecc_word_codec_chk #(.DATA_W(DATA_W), .CB_W(CB_W)) u_chk (.*);

// File: tb/ecc_word_codec_bench.sv
`timescale 1ns/1ps
module ecc_word_codec_bench;

  localparam int DW = 16;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ecc_off = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_force = 1'b0;
  logic [CW-1:0] wr_cb = '0;
  logic          wr_valid_o;
  logic [DW-1:0] wr_data_o;
  logic [CW-1:0] wr_cb_o;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [CW-1:0] rd_cb = '0;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic [CW-1:0] rd_cb_raw_o;
  logic          sgl_o;
  logic          dbl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ecc_word_codec u_ecc_word_codec (
    .clk_i                  (clk),
    .rst_ni                 (rst_n),
    .ecc_off_i              (ecc_off),
    .wr_valid_i             (wr_valid),
    .wr_data_i              (wr_data),
    .wr_cb_force_i          (wr_force),
    .wr_cb_i                (wr_cb),
    .wr_valid_o             (wr_valid_o),
    .wr_data_o              (wr_data_o),
    .wr_cb_o                (wr_cb_o),
    .rd_valid_i             (rd_valid),
    .rd_data_i              (rd_data),
    .rd_cb_i                (rd_cb),
    .rd_valid_o             (rd_valid_o),
    .rd_data_o              (rd_data_o),
    .rd_cb_raw_o            (rd_cb_raw_o),
    .single_err_corrected_o (sgl_o),
    .double_err_detected_o  (dbl_o)
  );

  // ---- model from the requirements ----
  function automatic int m_pos(int idx);
    int q = 2;
    int n = -1;
    while (n < idx) begin
      q++;
      if ((q & (q - 1)) != 0) n++;
    end
    return q;
  endfunction

  function automatic logic [CW-1:0] m_enc(logic [DW-1:0] d);
    logic [31:0] cw = '0;
    logic [CW-1:0] c = '0;
    for (int i = 0; i < DW; i++) cw[m_pos(i)] = d[i];
    for (int k = 0; k < CW - 1; k++)
      for (int q = 1; q <= 21; q++)
        if (q[k]) c[k] = c[k] ^ cw[q];
    c[CW-1] = (^d) ^ (^c[CW-2:0]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one read, find its output cycle, check it and the quiet cycle after
  task automatic do_read(input logic [DW-1:0] d, input logic [CW-1:0] c, input bit off,
                         input logic [DW-1:0] exp_d, input bit exp_s, input bit exp_db,
                         input int exp_lat, input string req);
    int lat = 0;
    logic [DW-1:0] got_d = '0;
    logic [CW-1:0] got_c = '0;
    bit got_s = 0, got_db = 0;
    rd_valid = 1'b1; rd_data = d; rd_cb = c; ecc_off = off;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k == 1) begin rd_valid = 1'b0; ecc_off = 1'b0; end
      if (rd_valid_o && lat == 0) begin
        lat = k; got_d = rd_data_o; got_c = rd_cb_raw_o; got_s = sgl_o; got_db = dbl_o;
      end else if (lat != 0) begin
        chk(!rd_valid_o && !sgl_o && !dbl_o, "R11 single pulse", {rd_valid_o, sgl_o, dbl_o}, 0);
      end
    end
    chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    chk(got_d == exp_d, {req, " data"}, got_d, exp_d);
    chk(got_s == exp_s && got_db == exp_db, {req, " flags"}, {got_s, got_db}, {exp_s, exp_db});
    chk(got_c == c, "R9 raw check bits", got_c, c);
  endtask

  task automatic do_write(input logic [DW-1:0] d, input bit force_en, input logic [CW-1:0] fc,
                          output logic [CW-1:0] cb_out);
    wr_valid = 1'b1; wr_data = d; wr_force = force_en; wr_cb = fc;
    @(negedge clk);
    wr_valid = 1'b0; wr_force = 1'b0;
    chk(wr_valid_o && wr_data_o == d, "R2 write valid/data", {wr_valid_o, wr_data_o}, {1'b1, d});
    cb_out = wr_cb_o;
  endtask

  task automatic t_reset();
    chk(!wr_valid_o && !rd_valid_o && !sgl_o && !dbl_o, "R1 in reset",
        {wr_valid_o, rd_valid_o, sgl_o, dbl_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid_o && !rd_valid_o && !sgl_o && !dbl_o, "R1 after release",
        {wr_valid_o, rd_valid_o, sgl_o, dbl_o}, 0);
  endtask

  task automatic t_encode();
    logic [DW-1:0] pats [5] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h1234, 16'h8001};
    foreach (pats[i]) begin
      logic [CW-1:0] c;
      do_write(pats[i], 1'b0, '0, c);
      chk(c == m_enc(pats[i]), "R2 check bits", c, m_enc(pats[i]));
    end
  endtask

  task automatic t_force();
    logic [CW-1:0] c;
    do_write(16'h5A5A, 1'b1, 6'h2A, c);
    chk(c == 6'h2A, "R3 forced check bits", c, 6'h2A);
    do_read(16'h5A5A, 6'h2A, 1'b1, 16'h5A5A, 0, 0, 1, "R8 raw read of forced word");
  endtask

  task automatic t_clean();
    logic [DW-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hC3A5, 16'h7E01};
    foreach (pats[i]) do_read(pats[i], m_enc(pats[i]), 1'b0, pats[i], 0, 0, 1, "R4 clean");
  endtask

  task automatic t_single_data();
    logic [DW-1:0] d = 16'hA5C3;
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] bad = d ^ (DW'(1) << i);
      do_read(bad, m_enc(d), 1'b0, d, 1, 0, 2, "R5 data bit");
    end
  endtask

  task automatic t_single_check();
    logic [DW-1:0] d = 16'h3C96;
    for (int k = 0; k < CW; k++) begin
      logic [CW-1:0] bad = m_enc(d) ^ (CW'(1) << k);
      do_read(d, bad, 1'b0, d, 1, 0, 2, "R6 check bit");
    end
  endtask

  task automatic t_double();
    logic [DW-1:0] d = 16'h0F0F;
    logic [DW-1:0] b;
    b = d ^ 16'h0003;
    do_read(b, m_enc(d), 1'b0, b, 0, 1, 2, "R7 two data bits");
    b = d ^ 16'h0204;
    do_read(b, m_enc(d), 1'b0, b, 0, 1, 2, "R7 two data bits far");
    b = d ^ 16'h0004;
    do_read(b, m_enc(d) ^ 6'h02, 1'b0, b, 0, 1, 2, "R7 data plus check bit");
    // positions 17 and 14 XOR to 31, plus overall bit: parity wrong, syndrome past 21
    b = d ^ (DW'(1) << 11) ^ (DW'(1) << 9);
    do_read(b, m_enc(d) ^ 6'h20, 1'b0, b, 0, 1, 2, "R7 syndrome out of range");
  endtask

  task automatic t_ecc_off();
    logic [DW-1:0] d = 16'h9999;
    do_read(d ^ 16'h0010, m_enc(d), 1'b1, d ^ 16'h0010, 0, 0, 1, "R8 single err ignored");
    do_read(d ^ 16'h0030, m_enc(d), 1'b1, d ^ 16'h0030, 0, 0, 1, "R8 double err ignored");
  endtask

  task automatic t_order();
    logic [DW-1:0] a = 16'h1111;
    logic [DW-1:0] b = 16'h2222;
    rd_valid = 1'b1; rd_data = a ^ 16'h0100; rd_cb = m_enc(a);
    @(negedge clk);
    chk(!rd_valid_o, "R10 slow read not early", rd_valid_o, 0);
    rd_data = b; rd_cb = m_enc(b);
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rd_valid_o && rd_data_o == a && sgl_o, "R10 first read out", {rd_valid_o, sgl_o, rd_data_o},
        {2'b11, a});
    @(negedge clk);
    chk(rd_valid_o && rd_data_o == b && !sgl_o && !dbl_o, "R10 second read in order",
        {rd_valid_o, sgl_o, rd_data_o}, {2'b10, b});
    @(negedge clk);
    chk(!rd_valid_o, "R10 drained", rd_valid_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_encode();
    t_force();
    t_clean();
    t_single_data();
    t_single_check();
    t_double();
    t_ecc_off();
    t_order();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule